// File: doc/BRIEF.md
# Bus Cycle Timeout Monitor

This block watches every bus cycle on a shared bus and ends any cycle that is never terminated. Each cycle belongs to one of two masters: the external processor or one of the internal bus masters. A down counter is loaded when the cycle starts. Each master has its own pair of normal termination strobes, an acknowledge and an error. When the owning master sees either one, the counter stops. If neither arrives within the programmed number of clocks, the block ends the cycle itself. It does this with a one-clock forced error that goes to the master that owns the cycle.

Software can change the timeout length and can turn the forced termination off through a one-cycle register write strobe. After reset the timeout is 1024 clocks and the monitor is enabled. A new limit applies only to cycles that start after the write, so a cycle already in flight is timed with the limit it was loaded with.

Top module: `cyc_timeout_mon`

## Requirements
- R1: While reset is held and in the first clock after it, `frc_ext_err` and `frc_int_err` are 0. Reset sets the limit to 1024 and the enable to 1.
- R2: A clock edge with `cyc_start`=1 opens a cycle. The owner is sampled from `cyc_own_int` (0 = external processor, 1 = internal master). The count is loaded with the limit held before that edge.
- R3: A cycle is closed without any forced error if the owner's own acknowledge or error strobe is high at any of the N edges after the start edge. External cycles use `ext_ack`/`ext_err` and internal cycles use `int_ack`/`int_err`. The other master's strobes have no effect on the cycle.
- R4: An external cycle with no termination at edges 1..N after its start raises `frc_ext_err` for exactly one clock, in the clock that follows edge N. `frc_int_err` stays 0.
- R5: An internal cycle with no termination at edges 1..N raises `frc_int_err` for exactly one clock, in the clock that follows edge N. `frc_ext_err` stays 0.
- R6: A termination strobe that is high at edge N, the edge where expiry would happen, wins. No forced error follows.
- R7: A cycle produces at most one forced error. After the error the block is idle until the next `cyc_start`. The two forced outputs are never high together.
- R8: `cfg_wr`=1 at an edge loads `cfg_limit` and `cfg_enable`. The new limit is used from the next start edge after the write. A start in the same clock as the write still uses the old limit.
- R9: With the enable at 0, an expired cycle is closed silently and both forced outputs stay 0.
- R10: A programmed limit of 0 behaves as a limit of 1.
- R11: A `cyc_start` while a cycle is open abandons the old cycle. The count restarts and the owner is taken again.
- R12: With the reset limit, an unterminated external cycle is forced after exactly 1024 clocks.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cyc_start | input | 1 | One-clock pulse at the start of a bus cycle |
| cyc_own_int | input | 1 | Owner of the starting cycle: 1 internal master, 0 external processor |
| ext_ack | input | 1 | Normal transfer acknowledge for an external-processor cycle |
| ext_err | input | 1 | Transfer error termination for an external-processor cycle |
| int_ack | input | 1 | Data strobe acknowledge for an internal-master cycle |
| int_err | input | 1 | Bus error termination for an internal-master cycle |
| cfg_wr | input | 1 | Register write strobe |
| cfg_limit | input | LIM_W | Timeout length in clocks, taken on `cfg_wr` |
| cfg_enable | input | 1 | Monitor enable, taken on `cfg_wr` |
| frc_ext_err | output | 1 | Forced transfer-error acknowledge toward the external processor |
| frc_int_err | output | 1 | Forced bus error toward the internal masters |

## Verification
The assertions assume that termination strobes matter only while a cycle is open. They also assume that a new start normally arrives only after the previous cycle has closed. The restart case (R11) is the one deliberate exception, and the bench exercises it once on purpose. Stimulus is driven on the falling edge and holds `cyc_start` and each strobe for a single clock. This keeps the start and termination edges unambiguous. Register writes are placed both inside open cycles and on the start edge, so that the late-effect rule is exercised at its boundary.

// File: rtl/cto_pkg.sv
package cto_pkg;
  // Which master owns the cycle being timed
  typedef enum logic {
    OWN_EXT = 1'b0,
    OWN_INT = 1'b1
  } owner_e;

  localparam int unsigned NUM_OWN = 2;
endpackage

// File: rtl/cto_cfg_regs.sv
// Timeout limit and enable; software updates through a write strobe.
module cto_cfg_regs #(
  parameter int unsigned LIM_W     = 16,
  parameter int unsigned RST_LIMIT = 1024
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr,
  input  logic [LIM_W-1:0] wr_limit,
  input  logic             wr_enable,
  output logic [LIM_W-1:0] limit_q,
  output logic             enable_q
);
  localparam logic [LIM_W-1:0] LIMIT_INIT = LIM_W'(RST_LIMIT);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      limit_q  <= LIMIT_INIT;
      enable_q <= 1'b1;
    end else if (wr) begin
      limit_q  <= wr_limit;
      enable_q <= wr_enable;
    end
  end
endmodule

// File: rtl/cto_owner.sv
// Captures the owner at cycle start and selects that owner's termination pair.
module cto_owner
  import cto_pkg::*;
(
  input  logic   clk,
  input  logic   rst_n,
  input  logic   start,
  input  logic   own_int_in,
  input  logic   ext_ack,
  input  logic   ext_err,
  input  logic   int_ack,
  input  logic   int_err,
  output owner_e own_q,
  output logic   term
);
  logic [NUM_OWN-1:0] done_vec;

  assign done_vec[OWN_EXT] = ext_ack | ext_err;
  assign done_vec[OWN_INT] = int_ack | int_err;
  assign term = done_vec[own_q];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     own_q <= OWN_EXT;
    else if (start) own_q <= own_int_in ? OWN_INT : OWN_EXT;
  end
endmodule

// File: rtl/cto_counter.sv
// Down counter per cycle; flags expiry on the edge where the count runs out.
module cto_counter #(
  parameter int unsigned LIM_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic [LIM_W-1:0] limit,
  input  logic             term,
  output logic             busy,
  output logic             expire
);
  localparam logic [LIM_W-1:0] ONE = LIM_W'(1);

  logic [LIM_W-1:0] cnt_q;
  logic [LIM_W-1:0] load_val;

  // A zero limit is promoted to one so the counter never wraps
  assign load_val = (limit == '0) ? ONE : limit;

  // Termination and a fresh start both outrank expiry
  assign expire = busy && !start && !term && (cnt_q == ONE);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy  <= 1'b0;
      cnt_q <= '0;
    end else if (start) begin
      busy  <= 1'b1;
      cnt_q <= load_val;
    end else if (busy) begin
      if (term || (cnt_q == ONE)) begin
        busy <= 1'b0;
      end else begin
        cnt_q <= cnt_q - ONE;
      end
    end
  end
endmodule

// File: rtl/cto_err_route.sv
// One registered forced-error pulse per master, steered by the cycle owner.
module cto_err_route
  import cto_pkg::*;
(
  input  logic               clk,
  input  logic               rst_n,
  input  logic               expire,
  input  logic               enable,
  input  owner_e             own_q,
  output logic [NUM_OWN-1:0] frc
);
  for (genvar g = 0; g < NUM_OWN; g++) begin : g_dst
    logic sel;
    assign sel = (own_q == owner_e'(1'(g)));
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) frc[g] <= 1'b0;
      else        frc[g] <= expire && enable && sel;
    end
  end
endmodule

// File: rtl/cyc_timeout_mon.sv
module cyc_timeout_mon
  import cto_pkg::*;
#(
  parameter int unsigned LIM_W     = 16,
  parameter int unsigned RST_LIMIT = 1024
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cyc_start,
  input  logic             cyc_own_int,
  input  logic             ext_ack,
  input  logic             ext_err,
  input  logic             int_ack,
  input  logic             int_err,
  input  logic             cfg_wr,
  input  logic [LIM_W-1:0] cfg_limit,
  input  logic             cfg_enable,
  output logic             frc_ext_err,
  output logic             frc_int_err
);
  logic [LIM_W-1:0]   limit_q;
  logic               enable_q;
  owner_e             own_q;
  logic               own_int_q;
  logic               term;
  logic               busy;
  logic               expire;
  logic [NUM_OWN-1:0] frc;

  cto_cfg_regs #(.LIM_W(LIM_W), .RST_LIMIT(RST_LIMIT)) u_cfg (
    .clk(clk), .rst_n(rst_n), .wr(cfg_wr), .wr_limit(cfg_limit),
    .wr_enable(cfg_enable), .limit_q(limit_q), .enable_q(enable_q)
  );

  cto_owner u_own (
    .clk(clk), .rst_n(rst_n), .start(cyc_start), .own_int_in(cyc_own_int),
    .ext_ack(ext_ack), .ext_err(ext_err), .int_ack(int_ack), .int_err(int_err),
    .own_q(own_q), .term(term)
  );

  cto_counter #(.LIM_W(LIM_W)) u_cnt (
    .clk(clk), .rst_n(rst_n), .start(cyc_start), .limit(limit_q),
    .term(term), .busy(busy), .expire(expire)
  );

  cto_err_route u_route (
    .clk(clk), .rst_n(rst_n), .expire(expire), .enable(enable_q),
    .own_q(own_q), .frc(frc)
  );

  assign own_int_q   = (own_q == OWN_INT);
  assign frc_ext_err = frc[OWN_EXT];
  assign frc_int_err = frc[OWN_INT];
endmodule

// File: rtl/cyc_timeout_mon_chk.sv
module cyc_timeout_mon_chk (
  input logic clk,
  input logic rst_n,
  input logic ext_ack,
  input logic ext_err,
  input logic int_ack,
  input logic int_err,
  input logic frc_ext_err,
  input logic frc_int_err,
  input logic busy,
  input logic own_int_q,
  input logic enable_q
);
  logic owner_done;
  assign owner_done = own_int_q ? (int_ack || int_err) : (ext_ack || ext_err);

  // R7
  excl_frc_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(frc_ext_err && frc_int_err));

  // R4
  ext_one_clk_chk: assert property (@(posedge clk) disable iff (!rst_n)
    frc_ext_err |=> !frc_ext_err);

  // R5
  int_one_clk_chk: assert property (@(posedge clk) disable iff (!rst_n)
    frc_int_err |=> !frc_int_err);

  // R6
  term_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && owner_done) |=> !(frc_ext_err || frc_int_err));

  // R9
  disabled_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !enable_q |=> !(frc_ext_err || frc_int_err));

  // R7
  idle_after_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (frc_ext_err || frc_int_err) |-> !busy);

  // R4
  ext_owner_chk: assert property (@(posedge clk) disable iff (!rst_n)
    frc_ext_err |-> $past(busy && !own_int_q));

  // R5
  int_owner_chk: assert property (@(posedge clk) disable iff (!rst_n)
    frc_int_err |-> $past(busy && own_int_q));
endmodule

bind cyc_timeout_mon cyc_timeout_mon_chk u_chk (
  .clk(clk), .rst_n(rst_n),
  .ext_ack(ext_ack), .ext_err(ext_err), .int_ack(int_ack), .int_err(int_err),
  .frc_ext_err(frc_ext_err), .frc_int_err(frc_int_err),
  .busy(busy), .own_int_q(own_int_q), .enable_q(enable_q)
);

// File: tb/cyc_timeout_mon_tb.sv
`timescale 1ns/1ps
module cyc_timeout_mon_tb;
  localparam int LIM_W = 16;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cyc_start = 0, cyc_own_int = 0;
  logic ext_ack = 0, ext_err = 0, int_ack = 0, int_err = 0;
  logic cfg_wr = 0, cfg_enable = 1;
  logic [LIM_W-1:0] cfg_limit = '0;
  logic frc_ext_err, frc_int_err;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #10 clk = ~clk;

  cyc_timeout_mon #(.LIM_W(LIM_W), .RST_LIMIT(1024)) u_dut (
    .clk(clk), .rst_n(rst_n), .cyc_start(cyc_start), .cyc_own_int(cyc_own_int),
    .ext_ack(ext_ack), .ext_err(ext_err), .int_ack(int_ack), .int_err(int_err),
    .cfg_wr(cfg_wr), .cfg_limit(cfg_limit), .cfg_enable(cfg_enable),
    .frc_ext_err(frc_ext_err), .frc_int_err(frc_int_err)
  );

  // Behavioural reference: state as plain integers, updated at each edge
  int m_lim, m_en, m_busy, m_own, m_left, m_ftea, m_fberr;
  initial begin
    m_lim = 1024; m_en = 1; m_busy = 0; m_own = 0; m_left = 0; m_ftea = 0; m_fberr = 0;
  end

  always @(posedge clk) begin
    if (!rst_n) begin
      m_lim = 1024; m_en = 1; m_busy = 0; m_own = 0; m_left = 0; m_ftea = 0; m_fberr = 0;
    end else begin
      int nt, nb, fin;
      nt = 0; nb = 0;
      if (cyc_start) begin
        m_busy = 1;
        m_own = int'(cyc_own_int);
        m_left = (m_lim == 0) ? 1 : m_lim;
      end else if (m_busy != 0) begin
        fin = (m_own != 0) ? int'(int_ack | int_err) : int'(ext_ack | ext_err);
        if (fin != 0) m_busy = 0;
        else begin
          m_left = m_left - 1;
          if (m_left == 0) begin
            m_busy = 0;
            if (m_en != 0) begin
              if (m_own != 0) nb = 1; else nt = 1;
            end
          end
        end
      end
      if (cfg_wr) begin
        m_lim = int'(cfg_limit);
        m_en = int'(cfg_enable);
      end
      m_ftea = nt;
      m_fberr = nb;
    end
  end

  // Compare on every falling edge, away from the active edge
  always @(negedge clk) begin
    if (rst_n && !done) begin
      checks++;
      if (int'(frc_ext_err) != m_ftea) begin
        errors++;
        $display("FAIL R4 frc_ext_err model compare at %0t: got %0d expected %0d", $time, frc_ext_err, m_ftea);
      end
      checks++;
      if (int'(frc_int_err) != m_fberr) begin
        errors++;
        $display("FAIL R5 frc_int_err model compare at %0t: got %0d expected %0d", $time, frc_int_err, m_fberr);
      end
    end
  end

  task automatic check(input string tag, input int got, input int exp);
    checks++;
    if (got != exp) begin
      errors++;
      $display("FAIL %s: got %0d expected %0d", tag, got, exp);
    end
  endtask

  task automatic write_cfg(input int lim, input bit en);
    cfg_wr = 1; cfg_limit = LIM_W'(lim); cfg_enable = en;
    @(posedge clk); @(negedge clk);
    cfg_wr = 0;
  endtask

  // term_kind: 0 none, 1 ack, 2 err; other_master drives the non-owner's strobe
  task automatic run_cycle(input string tag, input bit own, input int n, input int term_at,
                           input int term_kind, input bit other_master, input int exp_fire);
    int fire_at, fires, wrong;
    fire_at = 0; fires = 0; wrong = 0;
    cyc_start = 1; cyc_own_int = own;
    @(posedge clk); @(negedge clk);
    cyc_start = 0;
    for (int k = 1; k <= n + 4; k++) begin
      if (k == term_at && term_kind != 0) begin
        if ((own ^ other_master) != 0) begin
          int_ack = (term_kind == 1); int_err = (term_kind == 2);
        end else begin
          ext_ack = (term_kind == 1); ext_err = (term_kind == 2);
        end
      end
      @(posedge clk); @(negedge clk);
      ext_ack = 0; ext_err = 0; int_ack = 0; int_err = 0;
      if (frc_ext_err || frc_int_err) begin
        fires++;
        if (fire_at == 0) fire_at = k;
        if ((own ? frc_ext_err : frc_int_err) == 1'b1) wrong++;
      end
    end
    check({tag, " fire clock"}, fire_at, exp_fire);
    check({tag, " R7 single error"}, (fires > 1) ? fires : 0, 0);
    check({tag, " wrong master pulse"}, wrong, 0);
  endtask

  initial begin
    // R1: reset state
    repeat (3) @(negedge clk);
    check("R1 frc_ext_err in reset", int'(frc_ext_err), 0);
    check("R1 frc_int_err in reset", int'(frc_int_err), 0);
    rst_n = 1;
    @(negedge clk);
    check("R1 outputs idle after reset", int'(frc_ext_err | frc_int_err), 0);

    // R12 / R4: reset limit, external cycle unterminated
    run_cycle("R12 default ext timeout", 1'b0, 1024, 0, 0, 1'b0, 1024);
    // R2 / R5: internal owner with reset limit
    run_cycle("R5 default int timeout", 1'b1, 1024, 0, 0, 1'b0, 1024);

    write_cfg(5, 1'b1);
    run_cycle("R4 ext limit 5", 1'b0, 5, 0, 0, 1'b0, 5);
    run_cycle("R5 int limit 5", 1'b1, 5, 0, 0, 1'b0, 5);
    // R3: normal terminations
    run_cycle("R3 ext ack early", 1'b0, 5, 2, 1, 1'b0, 0);
    run_cycle("R3 ext err early", 1'b0, 5, 1, 2, 1'b0, 0);
    run_cycle("R3 int ack early", 1'b1, 5, 3, 1, 1'b0, 0);
    run_cycle("R3 int err early", 1'b1, 5, 4, 2, 1'b0, 0);
    // R3: other master's strobes ignored
    run_cycle("R3 int strobe on ext cycle", 1'b0, 5, 2, 1, 1'b1, 5);
    run_cycle("R3 ext strobe on int cycle", 1'b1, 5, 2, 2, 1'b1, 5);
    // R6: termination on the expiry edge wins
    run_cycle("R6 ext ack at expiry", 1'b0, 5, 5, 1, 1'b0, 0);
    run_cycle("R6 int err at expiry", 1'b1, 5, 5, 2, 1'b0, 0);
    run_cycle("R6 ext one clock late", 1'b0, 5, 6, 1, 1'b0, 5);

    // R8: write during an open cycle keeps the old limit for it
    begin
      int fire_at;
      fire_at = 0;
      cyc_start = 1; cyc_own_int = 0;
      @(posedge clk); @(negedge clk);
      cyc_start = 0;
      cfg_wr = 1; cfg_limit = 16'd8; cfg_enable = 1;
      for (int k = 1; k <= 9; k++) begin
        @(posedge clk); @(negedge clk);
        cfg_wr = 0;
        if (frc_ext_err && fire_at == 0) fire_at = k;
      end
      check("R8 in-flight cycle keeps old limit", fire_at, 5);
    end
    run_cycle("R8 next cycle uses new limit", 1'b0, 8, 0, 0, 1'b0, 8);
    // R8: write in the same clock as a start
    begin
      int fire_at;
      fire_at = 0;
      cyc_start = 1; cyc_own_int = 1;
      cfg_wr = 1; cfg_limit = 16'd3; cfg_enable = 1;
      @(posedge clk); @(negedge clk);
      cyc_start = 0; cfg_wr = 0;
      for (int k = 1; k <= 11; k++) begin
        @(posedge clk); @(negedge clk);
        if (frc_int_err && fire_at == 0) fire_at = k;
      end
      check("R8 write on start edge is late", fire_at, 8);
    end
    run_cycle("R8 limit 3 applies after", 1'b1, 3, 0, 0, 1'b0, 3);

    // R9: disabled monitor stays silent
    write_cfg(4, 1'b0);
    run_cycle("R9 disabled ext", 1'b0, 4, 0, 0, 1'b0, 0);
    run_cycle("R9 disabled int", 1'b1, 4, 0, 0, 1'b0, 0);

    // R10: zero limit behaves as one
    write_cfg(0, 1'b1);
    run_cycle("R10 zero limit ext", 1'b0, 1, 0, 0, 1'b0, 1);

    // R11: restart while open abandons the old cycle
    write_cfg(6, 1'b1);
    begin
      int ext_seen, int_at;
      ext_seen = 0; int_at = 0;
      cyc_start = 1; cyc_own_int = 0;
      @(posedge clk); @(negedge clk);
      cyc_start = 0;
      repeat (3) @(posedge clk);
      @(negedge clk);
      cyc_start = 1; cyc_own_int = 1;
      @(posedge clk); @(negedge clk);
      cyc_start = 0;
      for (int k = 1; k <= 10; k++) begin
        @(posedge clk); @(negedge clk);
        if (frc_ext_err) ext_seen++;
        if (frc_int_err && int_at == 0) int_at = k;
      end
      check("R11 abandoned ext cycle silent", ext_seen, 0);
      check("R11 restarted int cycle timing", int_at, 6);
    end

    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #(200000 * 20);
    if (!done) begin
      done = 1;
      checks++;
      errors++;
      $display("FAIL watchdog expired: got timeout expected completion");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule